// File: doc/BRIEF.md
# Dithered Fractional-Duty PWM Generator

This block drives a single pulse-width-modulated output from a free-running period counter whose length is chosen at run time. The duty command is a fixed-point word: its upper part is a whole number of counter ticks of high time, and its lowest four bits are a fraction of one tick. Each period, the whole part alone sets the pulse width. A small accumulator adds the fraction once per period, and each carry out of it lengthens that period's pulse by one tick. The average duty therefore gains four bits of resolution, at the price of one tick of jitter.

The duty word is captured only when a period begins, so software or an upstream controller can change it at any moment without producing a runt or a stretched pulse. A tick enable paces the whole block, so an external divider can set the tick rate. The block reports each new period with a one-cycle strobe. It also raises a one-cycle interrupt pulse when the counter arrives at its top value.

Top module: `fracpwm_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pwm_out`, `period_start` and `ovf_irq` are 0. The counter, the dither accumulator and the captured width clear to 0, so the output stays low for the whole first period after reset, whatever `duty_word` holds.
- R2: With `res_bits` = n in 1..20, the counter steps 0, 1, … 2^n−1 and then returns to 0, so one period lasts 2^n ticks. A value of 0 acts as 1 and a value above 20 acts as 20.
- R3: `duty_word[24:4]` is the whole part and `duty_word[3:0]` is the fraction. Both are captured only on the tick that ends a period, so a change made part way through a period has no effect on that period's pulse.
- R4: `pwm_out` is high exactly while the counter is below the effective width captured for the period. The number of high ticks in a period is therefore min(width, 2^n).
- R5: With a fraction of 0, every period's effective width equals the whole part.
- R6: At each period boundary a 4-bit accumulator (cleared by reset) adds the fraction. The effective width is the whole part plus the carry out of that addition. In any 16 consecutive periods with a constant fraction f, exactly f pulses are one tick longer.
- R7: An effective width of 0 keeps `pwm_out` low for the whole period. An effective width of 2^n or more keeps it high for the whole period.
- R8: `period_start` is a one-cycle pulse, high in the cycle right after the tick that wraps the counter to 0. It never stays high for two cycles in a row.
- R9: `ovf_irq` is a one-cycle pulse, high in the cycle right after the tick on which the counter steps onto 2^n−1. It occurs exactly once per period.
- R10: In a cycle with `tick_en` low, the counter, the accumulator and the captured width hold. On the next cycle `pwm_out` is unchanged and neither strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advances the counter and the dither state by one tick when high |
| res_bits | input | 5 | Counter resolution in bits (1 to 20; period is 2^res_bits ticks) |
| duty_word | input | 25 | Duty command: whole ticks in [24:4], sixteenths of a tick in [3:0] |
| pwm_out | output | 1 | PWM output |
| period_start | output | 1 | One-cycle strobe in the first cycle of each period |
| ovf_irq | output | 1 | One-cycle interrupt pulse when the counter reaches its top value |

## Verification
The bench builds the block with its default parameters: a 20-bit counter, a 21-bit whole part and a 4-bit fraction. This puts the full duty word and both the 0 and above-range clamps of `res_bits` at the ports. Because the resolution is a run-time input, the bench keeps periods between 2 and 64 ticks (resolutions 0 to 6). That makes the 16-period dither cycle, widths of 0, widths equal to and above the period, and resolution changes between periods all cheap to reach many times over. A pseudo-random tick pattern and a long stall show that everything is counted in ticks rather than clock cycles.

// File: rtl/fracpwm_pkg.sv
package fracpwm_pkg;

    // Default geometry of the generator.
    localparam int unsigned FP_FRAC_W  = 4;   // sixteenths of a tick
    localparam int unsigned FP_INT_W   = 21;  // whole ticks of high time
    localparam int unsigned FP_MAX_RES = 20;  // widest period counter

    // One tick's worth of counter events.
    typedef struct packed {
        logic wrap;    // the counter leaves its top value this tick
        logic arrive;  // the counter steps onto its top value this tick
    } step_t;

    // Map a requested resolution onto the supported range 1..hi.
    function automatic int unsigned clamp_res(input int unsigned req, input int unsigned hi);
        int unsigned res;
        res = req;
        if (res == 0) begin
            res = 1;
        end else if (res > hi) begin
            res = hi;
        end
        return res;
    endfunction

endpackage

// File: rtl/fracpwm_timer.sv
module fracpwm_timer
    import fracpwm_pkg::*;
#(
    parameter int unsigned MAX_RES = FP_MAX_RES,
    parameter int unsigned RES_W   = $clog2(MAX_RES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_en,
    input  logic [RES_W-1:0]   res_sel,
    output logic [MAX_RES-1:0] cnt_o,
    output logic [MAX_RES-1:0] lim_o,
    output logic               wrap_o,
    output logic               start_o,
    output logic               ovf_o
);

    logic [MAX_RES-1:0] cnt_q;
    int unsigned        res_eff;
    step_t              step;

    // Top value of the counter: 2^res - 1, saturating to all ones at MAX_RES.
    always_comb begin
        res_eff = clamp_res(32'(res_sel), MAX_RES);
        lim_o   = ~({MAX_RES{1'b1}} << res_eff);
    end

    // A counter left above a freshly lowered top value also wraps.
    always_comb begin
        step.wrap   = tick_en && (cnt_q >= lim_o);
        step.arrive = tick_en && (cnt_q < lim_o) && ((cnt_q + 1'b1) == lim_o);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            start_o <= 1'b0;
            ovf_o   <= 1'b0;
        end else begin
            if (step.wrap) begin
                cnt_q <= '0;
            end else if (tick_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
            start_o <= step.wrap;
            ovf_o   <= step.arrive;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = step.wrap;

endmodule

// File: rtl/fracpwm_dither.sv
module fracpwm_dither
    import fracpwm_pkg::*;
#(
    parameter int unsigned INT_W  = FP_INT_W,
    parameter int unsigned FRAC_W = FP_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [INT_W-1:0]  whole_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [INT_W:0]    width_o
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    // The carry out of the fraction accumulator lengthens this period by one tick.
    always_comb begin
        sum = {1'b0, acc_q} + {1'b0, frac_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            width_o <= '0;
        end else if (load) begin
            acc_q   <= sum[FRAC_W-1:0];
            width_o <= {1'b0, whole_i} + {{INT_W{1'b0}}, sum[FRAC_W]};
        end
    end

endmodule

// File: rtl/fracpwm_cmp.sv
module fracpwm_cmp #(
    parameter int unsigned CNT_W = 20,
    parameter int unsigned WID_W = 22
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [WID_W-1:0] width_i,
    output logic             pwm_o
);

    localparam int unsigned CMP_W = ((CNT_W > WID_W) ? CNT_W : WID_W) + 1;

    logic [CMP_W-1:0] cnt_ext;
    logic [CMP_W-1:0] wid_ext;

    // Both operands are widened so that widths past the period saturate high.
    always_comb begin
        cnt_ext = {{(CMP_W - CNT_W){1'b0}}, cnt_i};
        wid_ext = {{(CMP_W - WID_W){1'b0}}, width_i};
        pwm_o   = cnt_ext < wid_ext;
    end

endmodule

// File: rtl/fracpwm_gen.sv
module fracpwm_gen
    import fracpwm_pkg::*;
#(
    parameter int unsigned MAX_RES = FP_MAX_RES,
    parameter int unsigned FRAC_W  = FP_FRAC_W,
    parameter int unsigned INT_W   = FP_INT_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              tick_en,
    input  logic [$clog2(MAX_RES + 1)-1:0]    res_bits,
    input  logic [INT_W+FRAC_W-1:0]           duty_word,
    output logic                              pwm_out,
    output logic                              period_start,
    output logic                              ovf_irq
);

    localparam int unsigned RES_W = $clog2(MAX_RES + 1);
    localparam int unsigned WID_W = INT_W + 1;

    logic [MAX_RES-1:0] cnt_q;
    logic [MAX_RES-1:0] cnt_lim;
    logic               wrap;
    logic [WID_W-1:0]   width_q;

    fracpwm_timer #(
        .MAX_RES (MAX_RES),
        .RES_W   (RES_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .res_sel (res_bits),
        .cnt_o   (cnt_q),
        .lim_o   (cnt_lim),
        .wrap_o  (wrap),
        .start_o (period_start),
        .ovf_o   (ovf_irq)
    );

    fracpwm_dither #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_dither (
        .clk     (clk),
        .rst     (rst),
        .load    (wrap),
        .whole_i (duty_word[INT_W+FRAC_W-1:FRAC_W]),
        .frac_i  (duty_word[FRAC_W-1:0]),
        .width_o (width_q)
    );

    fracpwm_cmp #(
        .CNT_W (MAX_RES),
        .WID_W (WID_W)
    ) u_cmp (
        .cnt_i   (cnt_q),
        .width_i (width_q),
        .pwm_o   (pwm_out)
    );

endmodule

// File: rtl/fracpwm_chk.sv
module fracpwm_chk #(
    parameter int unsigned CNT_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             pwm_out,
    input logic             period_start,
    input logic             ovf_irq,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] lim
);

    // R1: outputs are quiet on the first cycle out of reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pwm_out && !period_start && !ovf_irq));

    // R2: a new period starts with the counter at zero
    p_start_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
        period_start |-> (cnt == '0));

    // R8: the period strobe lasts one cycle and follows a tick
    p_start_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        period_start |=> !period_start);
    p_start_ticked_r8: assert property (@(posedge clk) disable iff (rst)
        period_start |-> $past(tick_en));

    // R9: the interrupt lasts one cycle, with the counter at its top value
    p_ovf_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        ovf_irq |=> !ovf_irq);
    p_ovf_at_top_r9: assert property (@(posedge clk) disable iff (rst)
        ovf_irq |-> (cnt == lim));

    // R10: an idle cycle changes nothing visible
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> ($stable(pwm_out) && !period_start && !ovf_irq));

endmodule

bind fracpwm_gen fracpwm_chk #(.CNT_W(MAX_RES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_en      (tick_en),
    .pwm_out      (pwm_out),
    .period_start (period_start),
    .ovf_irq      (ovf_irq),
    .cnt          (cnt_q),
    .lim          (cnt_lim)
);

// File: tb/fracpwm_gen_bench.sv
module fracpwm_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [4:0]  res_bits = 5'd4;
    logic [24:0] duty_word = '0;
    logic        pwm_out;
    logic        period_start;
    logic        ovf_irq;

    fracpwm_gen u_fracpwm_gen (
        .clk          (clk),
        .rst          (rst),
        .tick_en      (tick_en),
        .res_bits     (res_bits),
        .duty_word    (duty_word),
        .pwm_out      (pwm_out),
        .period_start (period_start),
        .ovf_irq      (ovf_irq)
    );

    always #5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Resolution seen by the block (R2 clamp).
    function automatic int eff_res(input int r);
        if (r == 0) return 1;
        if (r > 20) return 20;
        return r;
    endfunction

    // ---------------- tick source ----------------
    bit         gap_mode = 0;
    bit         stall    = 0;
    logic [7:0] lfsr     = 8'hA5;

    initial begin
        forever begin
            @(posedge clk);
            #2;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tick_en = rst ? 1'b0 : (stall ? 1'b0 : (gap_mode ? lfsr[0] : 1'b1));
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        int high;
        int len;
        int whole;
    } exp_t;

    exp_t        exp_q[$];
    logic [24:0] duty_seen = '0;
    int          acc_m = 0;
    int          ext_seen = 0;

    // Predictor: for the period just begun, from the duty word held at the boundary (R3, R6).
    initial begin
        forever begin
            @(posedge period_start);
            #1;
            begin
                exp_t e;
                int   len;
                int   w;
                int   whole;
                int   frac;
                whole = int'(duty_seen[24:4]);
                frac  = int'(duty_seen[3:0]);
                acc_m = acc_m + frac;
                w     = whole + ((acc_m >= 16) ? 1 : 0);
                acc_m = acc_m % 16;
                len   = 1 << eff_res(int'(res_bits));
                e.len   = len;
                e.high  = (w > len) ? len : w;
                e.whole = whole;
                exp_q.push_back(e);
            end
        end
    end

    // Monitor: measures each period in ticks and compares at its end.
    initial begin
        exp_t pend;
        bit   pend_v = 0;
        int   hcnt = 0;
        int   tcnt = 0;
        int   ovfc = 0;
        bit   prev_ps = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                pend_v  = 0;
                hcnt    = 0;
                tcnt    = 0;
                ovfc    = 0;
                prev_ps = 0;
            end else begin
                if (period_start) begin
                    check(!prev_ps, "R8", "period_start width", 2, 1);
                    if (pend_v) begin
                        check(hcnt == pend.high, "R4", "high ticks in period", hcnt, pend.high);
                        check(tcnt == pend.len, "R2", "ticks in period", tcnt, pend.len);
                        check(ovfc == 1, "R9", "ovf_irq pulses in period", ovfc, 1);
                        if (pend.whole < pend.len && hcnt > pend.whole) ext_seen++;
                    end
                    pend_v = (exp_q.size() > 0);
                    if (pend_v) pend = exp_q.pop_front();
                    hcnt = 0;
                    tcnt = 0;
                    ovfc = 0;
                end
                if (tick_en) begin
                    tcnt++;
                    if (pwm_out) hcnt++;
                end
                if (ovf_irq) ovfc++;
                prev_ps = period_start;
            end
            duty_seen = duty_word;
        end
    end

    // ---------------- driver ----------------
    task automatic periods(input int n);
        repeat (n) @(posedge period_start);
    endtask

    task automatic set_cfg(input int res, input int whole, input int frac);
        res_bits  = 5'(res);
        duty_word = {21'(whole), 4'(frac)};
    endtask

    task automatic high_ticks_this_period(output int h);
        h = 0;
        @(negedge clk);
        forever begin
            if (tick_en && pwm_out) h++;
            @(negedge clk);
            if (period_start) break;
        end
    endtask

    task automatic run_all();
        int h;
        int e0;
        bit ok;
        logic p0;

        // R1: reset state, with a non-zero duty already applied
        set_cfg(4, 5, 0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(pwm_out == 0 && period_start == 0 && ovf_irq == 0, "R1", "outputs in reset",
              {pwm_out, period_start, ovf_irq}, 0);
        @(posedge clk);
        #1 rst = 1'b0;
        h = 0;
        forever begin
            @(negedge clk);
            if (period_start) break;
            if (pwm_out) h++;
        end
        check(h == 0, "R1", "high cycles in first period", h, 0);

        // R4, R5: no fraction, plain widths
        periods(4);
        set_cfg(4, 9, 0);
        periods(4);
        set_cfg(3, 2, 0);
        periods(4);

        // R6: half-tick dithering alternates
        set_cfg(4, 3, 8);
        periods(6);

        // R6: five extensions in every 16 periods
        set_cfg(4, 4, 5);
        periods(1);
        #6 e0 = ext_seen;
        periods(16);
        #6 check(ext_seen - e0 == 5, "R6", "extended pulses in 16 periods", ext_seen - e0, 5);

        // R7: constant low, exact fill, over-fill, fill reached by dithering
        set_cfg(4, 0, 0);
        periods(3);
        set_cfg(4, 16, 0);
        periods(3);
        set_cfg(4, 20, 0);
        periods(3);
        set_cfg(4, 15, 15);
        periods(17);

        // R3: a write in mid-period leaves the current pulse alone
        set_cfg(4, 10, 0);
        periods(1);
        fork
            begin
                #30 duty_word = {21'd2, 4'd0};
            end
            high_ticks_this_period(h);
        join
        check(h == 10, "R3", "high ticks after mid-period write", h, 10);
        periods(3);

        // R2: resolution changes, including the zero clamp
        set_cfg(2, 1, 4);
        periods(6);
        set_cfg(0, 1, 0);
        periods(5);
        set_cfg(6, 40, 3);
        periods(4);

        // R10: irregular ticks, then a long stall
        set_cfg(3, 3, 11);
        gap_mode = 1;
        periods(12);
        gap_mode = 0;
        periods(1);
        repeat (5) @(posedge clk);
        stall = 1;
        repeat (3) @(negedge clk);
        p0 = pwm_out;
        ok = 1;
        repeat (20) begin
            @(negedge clk);
            if (pwm_out !== p0 || period_start || ovf_irq || tick_en) ok = 0;
        end
        check(ok, "R10", "state held while stalled", ok, 1);
        stall = 0;
        periods(4);
    endtask

    initial begin
        fork
            run_all();
            begin
                #1500000;
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule